// File: doc/BRIEF.md
# Slave Port Default-Master Arbiter

This block decides which of several bus masters owns one slave port of a multi-master interconnect. Masters raise request lines. The block answers with a grant vector that is either one-hot or all zeros. Once a grant is given, it holds until the slave side pulses an end-of-access strobe. At that strobe the block re-arbitrates among any pending requesters in round-robin order, so a continuously busy slave loses no cycle between accesses.

When nothing is pending, a runtime-writable policy field chooses where the port rests:
- **None:** the port rests disconnected.
- **Last:** the port rests on the master that most recently won it.
- **Fixed:** the port rests on a master named by a 4-bit index.

A master whose grant is already raised while the port rests starts its access in the same cycle it requests, with no arbitration delay. Any other master is granted on the next clock edge.

Top module: `dm_slave_arbiter`

## Requirements
- R1: With policy code 2'b00 (none), an access that ends with no request pending leaves `grant` all zeros from the next cycle on.
- R2: With policy code 2'b01 (last), an access that ends with no request pending leaves `grant` one-hot on the master that was most recently granted.
- R3: With policy code 2'b10 (fixed), an idle port rests with `grant` one-hot on master `cfg_fixed`. Traffic from other masters does not move that resting point.
- R4: Policy code 2'b11 behaves as none. With policy 2'b10, a `cfg_fixed` value at or above the number of masters also behaves as none.
- R5: If an idle port rests on a master and that master raises its request, the access starts with `grant` already high in that same cycle, and `grant` stays unchanged on the following edge.
- R6: If an idle port gets a request from a master it does not rest on, `grant` for the chosen master rises on the next clock edge.
- R7: When several masters request at an access boundary, the winner is the first requester found searching upward, with wrap-around, from the master after the most recently granted one. After reset, that search starts at master 0.
- R8: While an access is in progress and `access_done` is low, `grant` does not change, even if requests or configuration change. While the port is idle, `access_done` has no effect.
- R9: If `access_done` arrives while requests are pending, the next winner is granted on the very next edge, with no all-zero cycle in between.
- R10: `grant` is always one-hot or all zeros. Reset clears it to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_MASTERS | Request line of each master |
| access_done | input | 1 | End-of-access strobe from the slave side |
| cfg_policy | input | 2 | Resting policy: 00 none, 01 last, 10 fixed, 11 treated as none |
| cfg_fixed | input | 4 | Index of the fixed resting master |
| grant | output | N_MASTERS | One-hot or zero grant to the masters |

## Verification
Every grant decision is registered once. The effect of a request, strobe or configuration change applied before a rising edge therefore appears on `grant` just after that edge. The bench drives each stimulus row on a falling edge and compares `grant` at the following falling edge, one full edge later. The zero-latency case is the exception: the resting grant must already be visible when the request is driven. For that case the bench also samples `grant` immediately after driving the request, before any edge.

// File: rtl/dm_arb_pkg.sv
package dm_arb_pkg;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'b00,
        PARK_LAST  = 2'b01,
        PARK_FIXED = 2'b10,
        PARK_RSVD  = 2'b11
    } park_pol_e;

    localparam int CFG_IDX_W = 4;

endpackage

// File: rtl/dm_rr_pick.sv
module dm_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(ptr) + k) % N;
            if (!found && req[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/dm_park_select.sv
module dm_park_select
    import dm_arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  park_pol_e              pol,
    input  logic [CFG_IDX_W-1:0]   fixed_idx,
    input  logic [IW-1:0]          last_idx,
    input  logic                   last_valid,
    output logic [N-1:0]           park_vec
);
    always_comb begin
        park_vec = '0;
        unique case (pol)
            PARK_LAST: begin
                for (int m = 0; m < N; m++)
                    if (last_valid && int'(last_idx) == m) park_vec[m] = 1'b1;
            end
            PARK_FIXED: begin
                for (int m = 0; m < N; m++)
                    if (int'(fixed_idx) == m) park_vec[m] = 1'b1;
            end
            default: park_vec = '0;
        endcase
    end
endmodule

// File: rtl/dm_slave_arbiter.sv
module dm_slave_arbiter
    import dm_arb_pkg::*;
#(
    parameter int N_MASTERS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req,
    input  logic                 access_done,
    input  logic [1:0]           cfg_policy,
    input  logic [3:0]           cfg_fixed,
    output logic [N_MASTERS-1:0] grant
);
    localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

    typedef struct packed {
        logic [N_MASTERS-1:0] grant;
        logic                 busy;
        logic [IW-1:0]        last_idx;
        logic                 last_valid;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic                 win_found;
    logic [IW-1:0]        win_idx;
    logic [N_MASTERS-1:0] park_vec;
    logic [N_MASTERS-1:0] win_vec;
    logic [IW-1:0]        held_idx;
    logic                 parked_hit;

    dm_rr_pick #(.N(N_MASTERS), .IW(IW)) u_pick (
        .req   (req),
        .ptr   (st_q.last_idx),
        .found (win_found),
        .idx   (win_idx)
    );

    dm_park_select #(.N(N_MASTERS), .IW(IW)) u_park (
        .pol        (park_pol_e'(cfg_policy)),
        .fixed_idx  (cfg_fixed),
        .last_idx   (st_q.last_idx),
        .last_valid (st_q.last_valid),
        .park_vec   (park_vec)
    );

    always_comb begin
        win_vec  = '0;
        held_idx = '0;
        for (int m = 0; m < N_MASTERS; m++) begin
            if (int'(win_idx) == m) win_vec[m] = 1'b1;
            if (st_q.grant[m])      held_idx   = IW'(m);
        end
    end

    assign parked_hit = |(st_q.grant & req);

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (access_done) begin
                if (win_found) begin
                    st_d.grant      = win_vec;
                    st_d.last_idx   = win_idx;
                    st_d.last_valid = 1'b1;
                end else begin
                    st_d.busy  = 1'b0;
                    st_d.grant = park_vec;
                end
            end
        end else if (parked_hit) begin
            st_d.busy       = 1'b1;
            st_d.last_idx   = held_idx;
            st_d.last_valid = 1'b1;
        end else if (win_found) begin
            st_d.busy       = 1'b1;
            st_d.grant      = win_vec;
            st_d.last_idx   = win_idx;
            st_d.last_valid = 1'b1;
        end else begin
            st_d.grant = park_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.grant      <= '0;
            st_q.busy       <= 1'b0;
            st_q.last_idx   <= IW'(N_MASTERS - 1);
            st_q.last_valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant = st_q.grant;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R10

    AST_HOLD_MID_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && !access_done |=> $stable(grant)); // R8

    AST_NONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && access_done && (req == '0) && (cfg_policy == 2'b00)
        |=> (grant == '0)); // R1

    AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && access_done && (|req) |=> (|grant)); // R9

    AST_IDLE_REQ_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy && (|req) |=> (|grant)); // R6

    AST_PARKED_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy && (|(grant & req)) |=> $stable(grant)); // R5

endmodule

// File: tb/sim_dm_slave_arbiter.sv
module sim_dm_slave_arbiter;
    localparam int N = 4;
    localparam int ROWS = 25;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         access_done = 1'b0;
    logic [1:0]   cfg_policy = 2'b00;
    logic [3:0]   cfg_fixed = 4'h0;
    logic [N-1:0] grant;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dm_slave_arbiter #(.N_MASTERS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .access_done(access_done),
        .cfg_policy(cfg_policy), .cfg_fixed(cfg_fixed), .grant(grant)
    );

    // {req, access_done, policy, fixed index, grant expected after the edge}
    localparam logic [14:0] TBL [0:ROWS-1] = '{
        {4'b0000, 1'b0, 2'b00, 4'd0, 4'b0000}, // R1 idle, none
        {4'b0010, 1'b0, 2'b00, 4'd0, 4'b0010}, // R6 one-cycle grant
        {4'b0010, 1'b0, 2'b00, 4'd0, 4'b0010}, // R8 held
        {4'b0000, 1'b1, 2'b00, 4'd0, 4'b0000}, // R1 release
        {4'b0101, 1'b0, 2'b00, 4'd0, 4'b0100}, // R7 after master 1
        {4'b0101, 1'b1, 2'b00, 4'd0, 4'b0001}, // R9 R7 wrap
        {4'b0100, 1'b1, 2'b00, 4'd0, 4'b0100}, // R9
        {4'b0000, 1'b1, 2'b01, 4'd0, 4'b0100}, // R2 rest on last
        {4'b0000, 1'b0, 2'b01, 4'd0, 4'b0100}, // R2 stays
        {4'b0100, 1'b0, 2'b01, 4'd0, 4'b0100}, // R5 parked hit
        {4'b0000, 1'b1, 2'b01, 4'd0, 4'b0100}, // R2
        {4'b1000, 1'b0, 2'b01, 4'd0, 4'b1000}, // R6 other master
        {4'b0000, 1'b1, 2'b01, 4'd0, 4'b1000}, // R2 new last
        {4'b0000, 1'b0, 2'b10, 4'd1, 4'b0010}, // R3 fixed rest
        {4'b0001, 1'b0, 2'b10, 4'd1, 4'b0001}, // R6 under fixed
        {4'b0000, 1'b1, 2'b10, 4'd1, 4'b0010}, // R3 back to fixed
        {4'b0010, 1'b0, 2'b10, 4'd1, 4'b0010}, // R5 fixed hit
        {4'b0000, 1'b1, 2'b10, 4'd5, 4'b0000}, // R4 index out of range
        {4'b0000, 1'b0, 2'b11, 4'd1, 4'b0000}, // R4 reserved code
        {4'b0000, 1'b0, 2'b10, 4'd1, 4'b0010}, // R3
        {4'b0000, 1'b0, 2'b00, 4'd1, 4'b0000}, // R1
        {4'b0001, 1'b0, 2'b00, 4'd0, 4'b0001}, // R7 from master 1
        {4'b0000, 1'b0, 2'b10, 4'd2, 4'b0001}, // R8 cfg change mid access
        {4'b0000, 1'b1, 2'b10, 4'd2, 4'b0100}, // R3
        {4'b0000, 1'b1, 2'b10, 4'd2, 4'b0100}  // R8 strobe ignored idle
    };

    task automatic check(input string rq, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: grant=%b expected=%b at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset", grant, 4'b0000);
        rst_n = 1'b1;
        for (int i = 0; i < ROWS; i++) begin
            {req, access_done, cfg_policy, cfg_fixed} = TBL[i][14:4];
            #1;
            if (i == 9)  check("R5 grant high before edge", grant, 4'b0100);
            if (i == 16) check("R5 fixed grant high before edge", grant, 4'b0010);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("row %0d (R1-R10 table)", i), grant, TBL[i][3:0]);
        end
        // R7 after reset the search starts at master 0; R10 reset clears grant
        rst_n = 1'b0; req = 4'b1111; access_done = 1'b0; cfg_policy = 2'b00;
        @(posedge clk); @(negedge clk);
        check("R10 reset mid-run", grant, 4'b0000);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R7 first winner after reset", grant, 4'b0001);
        access_done = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R7 R9 rotate to master 1", grant, 4'b0010);
        @(posedge clk); @(negedge clk);
        check("R7 rotate to master 2", grant, 4'b0100);
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        summary();
    end
endmodule